// File: doc/BRIEF.md
# Message-Signaled Interrupt Request Generator

This block converts a bank of internal interrupt request lines into single posted memory-write messages. Configuration inputs, held steady by the surrounding register logic, supply a global enable, a target address, a 16-bit base data word, the base-two logarithm of the number of allocated vectors, and an optional per-vector mask. A request on a line sets a pending bit for its vector. The block then emits one write whose data is the base word plus the vector number, to the shared target address.

Messages must not overtake the device's own posted data writes. The block therefore tracks how many of those writes are still in flight, through one pulse when a write is queued and one when it is handed off. It holds back a message until that count is zero.

The controlling state machine has three states. `ST_IDLE` waits for an eligible pending vector. `ST_DRAIN` waits for the posted-write count to reach zero. `ST_ISSUE` presents the message until it is accepted. Transitions:
- IDLE→DRAIN when the enable is set and some vector is eligible.
- DRAIN→IDLE when nothing is eligible any more.
- DRAIN→ISSUE when the count is zero. On this transition the lowest eligible vector is latched and its pending bit cleared.
- ISSUE→IDLE on acceptance.

Top module: `msi_gen`

## Requirements
- R1: After reset `msg_valid` is low, no vector is pending and the posted-write count is zero.
- R2: The allocated vector count is 2 to the power `cfg_vec_log2`. Values above 5 act as 5, which gives 32 vectors. Only vectors below the count are eligible.
- R3: A request on line i sets the pending bit of vector i modulo the vector count. Several requests folding onto one vector before it is sent yield a single message.
- R4: Message data equals `cfg_data` plus the vector number, modulo 2^16.
- R5: The upper 32 bits of `msg_addr` are zero unless `cfg_addr64` is set. The lower 32 bits always equal the low half of `cfg_addr`.
- R6: When several vectors are eligible, the lowest-numbered one is sent first.
- R7: When `cfg_mask_en` is set, a vector whose `cfg_mask` bit is 1 stays pending without being sent, and it is sent once the bit clears. When `cfg_mask_en` is clear, `cfg_mask` has no effect.
- R8: While `cfg_enable` is clear no message starts, but requests still set pending bits. These are sent after the enable is set again.
- R9: The posted-write count rises on `dw_push` and falls on `dw_pop`; a pop at zero is ignored. A message is latched only in a cycle where the count is zero, so a push in that same cycle is treated as later.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold steady. A message is accepted on a clock edge where both are high.
- R11: With no blocking condition, a request sampled at clock edge k makes `msg_valid` high after edge k+2. A new message can start no sooner than two edges after the previous acceptance.
- R12: A vector's pending bit clears when its message is latched. A request on the same vector at that same edge leaves it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Global message enable |
| cfg_addr64 | input | 1 | Use the upper address half |
| cfg_addr | input | 64 | Target address |
| cfg_data | input | 16 | Base data word |
| cfg_vec_log2 | input | 3 | Log2 of allocated vector count |
| cfg_mask_en | input | 1 | Per-vector masking in use |
| cfg_mask | input | 32 | Per-vector mask, 1 = masked |
| irq_req | input | 32 | Interrupt request lines, one pulse per event |
| dw_push | input | 1 | A device data write was queued |
| dw_pop | input | 1 | A device data write was handed off |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_valid | output | 1 | Message write request |
| msg_addr | output | 64 | Message write address |
| msg_data | output | 16 | Message write data |

## Verification
A corrupted pending bit or a wrong latched vector shows at the ports within three cycles of the triggering request. It appears as a missing, extra or misnumbered message on `msg_data`. A posted-write count that is off by one shows as a message starting while writes are still in flight, or never starting at all. The behavioural model predicts `msg_valid`, `msg_addr` and `msg_data` for every cycle. Any divergence is therefore reported in the first cycle it appears, not at the end of a scenario.

// File: rtl/msi_gen_pkg.sv
package msi_gen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_ISSUE = 2'd2
    } msi_state_e;
endpackage

// File: rtl/msi_pend.sv
module msi_pend #(
    parameter int NV     = 32,
    parameter int IDX_W  = 5,
    parameter int LOG2_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NV-1:0]     req,
    input  logic [LOG2_W-1:0] l_eff,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    output logic [NV-1:0]     pend
);
    logic [IDX_W:0]   span;
    logic [IDX_W-1:0] idx_mask;
    logic [NV-1:0]    fold;
    logic [NV-1:0]    pend_q;

    // Fold each request line onto the allocated range by keeping its low bits.
    always_comb begin
        span     = (IDX_W+1)'(1) << l_eff;
        idx_mask = IDX_W'(span - (IDX_W+1)'(1));
        fold     = '0;
        for (int i = 0; i < NV; i++) begin
            if (req[i]) begin
                fold[IDX_W'(i) & idx_mask] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            for (int j = 0; j < NV; j++) begin
                if (fold[j]) begin
                    pend_q[j] <= 1'b1;
                end else if (clr_en && (clr_idx == IDX_W'(j))) begin
                    pend_q[j] <= 1'b0;
                end
            end
        end
    end

    assign pend = pend_q;

    // R12: only a vector that is pending can be latched and cleared
    p_clear_pending_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> pend_q[clr_idx]);
endmodule

// File: rtl/msi_order.sv
module msi_order #(
    parameter int CNT_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    output logic drained
);
    logic [CNT_W-1:0] cnt_q;
    logic             pop_ok;

    assign pop_ok = pop && (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case ({push, pop_ok})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign drained = (cnt_q == '0);

    // R9: the in-flight count never wraps past its maximum
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt_q) |-> !(push && !pop));
endmodule

// File: rtl/msi_pick.sv
module msi_pick #(
    parameter int NV    = 32,
    parameter int IDX_W = 5
) (
    input  logic [NV-1:0]    elig,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |elig;
        idx = '0;
        for (int i = NV - 1; i >= 0; i--) begin
            if (elig[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/msi_gen.sv
module msi_gen
    import msi_gen_pkg::*;
#(
    parameter int NV     = 32,
    parameter int ADDR_W = 64,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 6,
    parameter int LOG2_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_addr64,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic [LOG2_W-1:0] cfg_vec_log2,
    input  logic              cfg_mask_en,
    input  logic [NV-1:0]     cfg_mask,
    input  logic [NV-1:0]     irq_req,
    input  logic              dw_push,
    input  logic              dw_pop,
    input  logic              msg_ready,
    output logic              msg_valid,
    output logic [ADDR_W-1:0] msg_addr,
    output logic [DATA_W-1:0] msg_data
);
    localparam int IDX_W    = $clog2(NV);
    localparam int LOG2_MAX = $clog2(NV);
    localparam int HALF     = ADDR_W / 2;

    msi_state_e        state_q, state_d;
    logic [LOG2_W-1:0] l_eff;
    logic [IDX_W:0]    nvec;
    logic [NV-1:0]     alloc;
    logic [NV-1:0]     pend;
    logic [NV-1:0]     elig;
    logic [NV-1:0]     mask_eff;
    logic              any_elig;
    logic [IDX_W-1:0]  pick_idx;
    logic              drained;
    logic              go;
    logic              take;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        l_eff = (cfg_vec_log2 > LOG2_W'(LOG2_MAX)) ? LOG2_W'(LOG2_MAX) : cfg_vec_log2;
        nvec  = (IDX_W+1)'(1) << l_eff;
        for (int j = 0; j < NV; j++) begin
            alloc[j] = ((IDX_W+1)'(j) < nvec);
        end
        mask_eff = cfg_mask_en ? cfg_mask : '0;
        elig     = pend & alloc & ~mask_eff;
    end

    msi_pend #(.NV(NV), .IDX_W(IDX_W), .LOG2_W(LOG2_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (irq_req),
        .l_eff   (l_eff),
        .clr_en  (take),
        .clr_idx (pick_idx),
        .pend    (pend)
    );

    msi_pick #(.NV(NV), .IDX_W(IDX_W)) u_pick (
        .elig (elig),
        .any  (any_elig),
        .idx  (pick_idx)
    );

    msi_order #(.CNT_W(CNT_W)) u_order (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (dw_push),
        .pop     (dw_pop),
        .drained (drained)
    );

    assign go   = cfg_enable && any_elig;
    assign take = (state_q == ST_DRAIN) && go && drained;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!go)          state_d = ST_IDLE;
                else if (drained) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (msg_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output registers: message latched on the DRAIN->ISSUE transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (take) begin
            addr_q <= {(cfg_addr64 ? cfg_addr[ADDR_W-1:HALF] : {(ADDR_W-HALF){1'b0}}),
                       cfg_addr[HALF-1:0]};
            data_q <= cfg_data + DATA_W'(pick_idx);
        end
    end

    assign msg_valid = (state_q == ST_ISSUE);
    assign msg_addr  = addr_q;
    assign msg_data  = data_q;

    // R10: request held steady under back-pressure
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R9: a message starts only after all earlier posted writes left
    p_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(drained));

    // R8: no message starts while disabled
    p_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(cfg_enable));

    // R7: a masked vector is never chosen
    p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(!(cfg_mask_en && cfg_mask[pick_idx])));

    // R2: only an allocated vector is chosen
    p_alloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(alloc[pick_idx] && pend[pick_idx]));

    // R11: at least two edges between acceptance and the next message
    p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);
endmodule

// File: tb/msi_gen_tb.sv
`timescale 1ns/1ps
module msi_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_addr64 = 1'b0;
    logic [63:0] cfg_addr = '0;
    logic [15:0] cfg_data = '0;
    logic [2:0]  cfg_vec_log2 = '0;
    logic        cfg_mask_en = 1'b0;
    logic [31:0] cfg_mask = '0;
    logic [31:0] irq_req = '0;
    logic        dw_push = 1'b0;
    logic        dw_pop = 1'b0;
    logic        msg_ready = 1'b1;
    logic        msg_valid;
    logic [63:0] msg_addr;
    logic [15:0] msg_data;

    always #2 clk = ~clk;

    msi_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_addr64(cfg_addr64),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_vec_log2(cfg_vec_log2),
        .cfg_mask_en(cfg_mask_en), .cfg_mask(cfg_mask), .irq_req(irq_req),
        .dw_push(dw_push), .dw_pop(dw_pop), .msg_ready(msg_ready),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";

    // Reference model state
    int          m_state;
    bit [31:0]   m_pend;
    int          m_cnt;
    logic [63:0] m_addr;
    logic [15:0] m_data;
    bit [31:0]   m_el;
    bit [31:0]   m_np;
    int          m_n;
    int          m_k;
    bit          m_go;

    logic [79:0] got_q[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_pend = '0; m_cnt = 0; m_addr = '0; m_data = '0;
        end else begin
            chk(msg_valid == (m_state == 2), cur_tag, "msg_valid", 64'(msg_valid), 64'(m_state == 2));
            if (m_state == 2 && msg_valid) begin
                chk(msg_addr == m_addr, cur_tag, "msg_addr", msg_addr, m_addr);
                chk(msg_data == m_data, cur_tag, "msg_data", 64'(msg_data), 64'(m_data));
            end
            if (msg_valid && msg_ready) got_q.push_back({msg_addr, msg_data});
            // advance model by one edge
            m_n = 1 << ((cfg_vec_log2 > 3'd5) ? 5 : int'(cfg_vec_log2));
            for (int j = 0; j < 32; j++)
                m_el[j] = m_pend[j] && (j < m_n) && !(cfg_mask_en && cfg_mask[j]);
            m_go = cfg_enable && (m_el != 0);
            m_np = m_pend;
            case (m_state)
                0: if (m_go) m_state = 1;
                1: begin
                    if (!m_go) m_state = 0;
                    else if (m_cnt == 0) begin
                        m_k = 0;
                        while (!m_el[m_k]) m_k++;
                        m_addr = {cfg_addr64 ? cfg_addr[63:32] : 32'h0, cfg_addr[31:0]};
                        m_data = cfg_data + 16'(m_k);
                        m_np[m_k] = 1'b0;
                        m_state = 2;
                    end
                end
                default: if (msg_ready) m_state = 0;
            endcase
            for (int i = 0; i < 32; i++)
                if (irq_req[i]) m_np[i % m_n] = 1'b1;
            m_pend = m_np;
            if (dw_push && !(dw_pop && m_cnt > 0)) m_cnt++;
            else if (!dw_push && dw_pop && m_cnt > 0) m_cnt--;
        end
    end

    task automatic step(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(input logic [31:0] lines);
        irq_req = lines; step(); irq_req = '0;
    endtask

    task automatic expect_msg(input logic [15:0] d, input logic [63:0] a, input string tag);
        logic [79:0] m;
        if (got_q.size() == 0) begin
            chk(1'b0, tag, "missing message data", 64'h0, 64'(d));
        end else begin
            m = got_q.pop_front();
            chk(m[15:0] == d, tag, "message data", 64'(m[15:0]), 64'(d));
            chk(m[79:16] == a, tag, "message address", m[79:16], a);
        end
    endtask

    task automatic expect_none(input string tag);
        chk(got_q.size() == 0, tag, "unexpected message count", 64'(got_q.size()), 64'h0);
        got_q.delete();
    endtask

    localparam logic [63:0] A_FULL = 64'hA5A5_0000_1000_0040;
    localparam logic [63:0] A_LOW  = 64'h0000_0000_1000_0040;

    bit wd_hit = 1'b0;

    initial begin
        fork
            begin
                step(3);
                rst_n = 1'b1;
                step();
                cur_tag = "R1";
                chk(msg_valid == 1'b0, "R1", "msg_valid after reset", 64'(msg_valid), 64'h0);
                cfg_addr = A_FULL; cfg_data = 16'h4000; cfg_vec_log2 = 3'd3; cfg_enable = 1'b1;
                step(5);
                chk(msg_valid == 1'b0, "R1", "msg_valid with nothing pending", 64'(msg_valid), 64'h0);
                expect_none("R1");

                cur_tag = "R11"; pulse(32'h4); step(6);
                expect_msg(16'h4002, A_LOW, "R5");

                cur_tag = "R6"; pulse(32'h2A); step(12);
                expect_msg(16'h4001, A_LOW, "R6");
                expect_msg(16'h4003, A_LOW, "R6");
                expect_msg(16'h4005, A_LOW, "R6");

                cur_tag = "R3"; cfg_vec_log2 = 3'd2; pulse(32'h40); step(6);
                expect_msg(16'h4002, A_LOW, "R3");
                cfg_vec_log2 = 3'd0; pulse(32'h28); step(8);
                expect_msg(16'h4000, A_LOW, "R3");
                expect_none("R3");
                cur_tag = "R2"; cfg_vec_log2 = 3'd7; pulse(32'h8000_0000); step(6);
                expect_msg(16'h401F, A_LOW, "R2");

                cur_tag = "R4"; cfg_vec_log2 = 3'd5; cfg_data = 16'hFFFF; pulse(32'h8); step(6);
                expect_msg(16'h0002, A_LOW, "R4");
                cur_tag = "R5"; cfg_addr64 = 1'b1; pulse(32'h1); step(6);
                expect_msg(16'hFFFF, A_FULL, "R5");
                cfg_addr64 = 1'b0; cfg_data = 16'h4000;

                cur_tag = "R7"; cfg_mask_en = 1'b1; cfg_mask = 32'h2; pulse(32'h12); step(10);
                expect_msg(16'h4004, A_LOW, "R7");
                expect_none("R7");
                cfg_mask = '0; step(6);
                expect_msg(16'h4001, A_LOW, "R7");
                cfg_mask_en = 1'b0; cfg_mask = 32'h4; pulse(32'h4); step(6);
                expect_msg(16'h4002, A_LOW, "R7");
                cfg_mask = '0;

                cur_tag = "R8"; cfg_enable = 1'b0; pulse(32'h80); step(10);
                expect_none("R8");
                cfg_enable = 1'b1; step(6);
                expect_msg(16'h4007, A_LOW, "R8");

                cur_tag = "R9"; dw_push = 1'b1; step(2); dw_push = 1'b0;
                pulse(32'h1); step(10);
                expect_none("R9");
                dw_pop = 1'b1; step(2); dw_pop = 1'b0; step(6);
                expect_msg(16'h4000, A_LOW, "R9");

                cur_tag = "R10"; msg_ready = 1'b0; pulse(32'h200); step(8);
                chk(msg_valid == 1'b1, "R10", "msg_valid under back-pressure", 64'(msg_valid), 64'h1);
                expect_none("R10");
                msg_ready = 1'b1; step(2);
                expect_msg(16'h4009, A_LOW, "R10");

                cur_tag = "R12";
                for (int c = 0; c < 3000; c++) begin
                    irq_req      = ($urandom_range(0, 3) == 0) ? $urandom : 32'h0;
                    msg_ready    = ($urandom_range(0, 3) != 0);
                    dw_push      = ($urandom_range(0, 5) == 0);
                    dw_pop       = ($urandom_range(0, 4) == 0);
                    cfg_mask_en  = ($urandom_range(0, 1) == 1);
                    if ($urandom_range(0, 20) == 0) cfg_mask = $urandom;
                    if ($urandom_range(0, 50) == 0) cfg_vec_log2 = 3'($urandom_range(0, 7));
                    if ($urandom_range(0, 40) == 0) cfg_enable = ~cfg_enable;
                    step();
                end
                irq_req = '0; dw_push = 1'b0; dw_pop = 1'b0; msg_ready = 1'b1;
                cfg_mask_en = 1'b0; cfg_enable = 1'b1; step(200);
                got_q.delete();
            end
            begin
                repeat (150000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) chk(1'b0, "R11", "watchdog expired", 64'h0, 64'h1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule